// File: doc/BRIEF.md
# Memory-Polynomial Lookup-Table Predistorter

This block linearises a power amplifier by predistorting a complex baseband stream before it reaches the amplifier. It keeps the newest sample and the four samples before it in a short history. Every history position, called a branch, has its own complex gain table. The table is addressed by the power of that branch's own sample. Each branch multiplies its sample by the gain it looks up, and the five complex products are added together. The sum is rounded and clamped to the output width. The tables hold gains that an external estimator derives from the odd-order terms of a memory polynomial. As a result, each gain is a function of even powers of the amplitude.

Software, or an adaptation engine, fills the tables through a write port that names a branch, an address and a complex gain. Samples are accepted on any cycle where the input valid is high. The history advances only on those cycles. Every accepted sample produces exactly one output a fixed number of cycles later. With the branch count set to one, the block reduces to a memoryless single-table predistorter.

Top module: `mpd_predistorter`

## Requirements
- R1: Reset clears `out_valid`, `out_i`, `out_q` and the whole sample history to zero. The first outputs after reset therefore see zero samples in the older branches.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid`, four clock edges later. `out_valid` is low on every other cycle.
- R3: The output is the sum, over branches q = 0..4, of x(n−q)·G_q(a_q). Here x(n−q) is the q-th most recent accepted sample and G_q is branch q's table. The complex product is (I·GI − Q·GQ) + j(I·GQ + Q·GI).
- R4: The address a_q is bits [31:24] of I² + Q² of branch q's own delayed sample, never of the current sample.
- R5: The history shifts by one position only on cycles with `in_valid` high. Idle cycles leave it unchanged.
- R6: Gains are signed 16-bit values with 14 fraction bits, so 16384 means 1.0. The sum is scaled down by 2^14 with rounding half up: floor((s + 8192) / 16384).
- R7: A rounded result above 32767 or below −32768 is clamped to that limit.
- R8: A table write with `tbl_we` high stores `{tbl_gain_i, tbl_gain_q}` at address `tbl_addr` of branch `tbl_sel`. The new gain is used from the next lookup on.
- R9: A table write whose `tbl_sel` is 5, 6 or 7 has no effect on any table.
- R10: `out_i` and `out_q` hold their previous values on every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Predistorted in-phase sample, signed |
| out_q | output | 16 | Predistorted quadrature sample, signed |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 3 | Branch index of the write |
| tbl_addr | input | 8 | Table address of the write |
| tbl_gain_i | input | 16 | Real part of the written gain, Q2.14 |
| tbl_gain_q | input | 16 | Imaginary part of the written gain, Q2.14 |

## Verification
The hardest case to reach is a branch whose delayed sample falls on a different table address than the current sample. A stream with full-scale amplitude swings between neighbouring samples creates this case. The tables therefore hold strongly address-dependent gains that differ per branch, so a design that indexed every table by the newest sample would produce visibly wrong sums. The stream also includes idle gaps, so a history that shifted on idle cycles would misalign the branches. Writes to the out-of-range branch indices target an address that a later sample actually uses. Rounding ties are created by seeding the first samples after reset with a gain of exactly one half.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

   // Rounding applied when the accumulated sum is scaled back to sample width.
   typedef enum logic [0:0] {
      RND_HALF_UP = 1'b0,
      RND_TRUNC   = 1'b1
   } rnd_e;

   // Clock edges from input capture to output register.
   localparam int unsigned PIPE_LATENCY = 4;

endpackage

// File: rtl/mpd_delay_line.sv
module mpd_delay_line #(
   parameter int DW   = 16,
   parameter int TAPS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic signed [DW-1:0] din_i,
   input  logic signed [DW-1:0] din_q,
   output logic signed [DW-1:0] hist_i [TAPS],
   output logic signed [DW-1:0] hist_q [TAPS]
);

   if (TAPS < 1) begin : g_bad_taps
      initial $fatal(1, "mpd_delay_line: TAPS must be at least 1");
   end

   for (genvar q = 0; q < TAPS; q++) begin : g_stage
      if (q == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_i[q] <= '0;
               hist_q[q] <= '0;
            end else if (push) begin
               hist_i[q] <= din_i;
               hist_q[q] <= din_q;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_i[q] <= '0;
               hist_q[q] <= '0;
            end else if (push) begin
               hist_i[q] <= hist_i[q-1];
               hist_q[q] <= hist_q[q-1];
            end
         end
      end
   end

   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> ($stable(hist_i[0]) && $stable(hist_q[0]) &&
                 $stable(hist_i[TAPS-1]) && $stable(hist_q[TAPS-1]))); // R5

endmodule

// File: rtl/mpd_branch.sv
module mpd_branch #(
   parameter int DW     = 16,
   parameter int CW     = 16,
   parameter int AW     = 8,
   parameter int SW     = 3,
   parameter int TAP_ID = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [DW-1:0]    s_i,
   input  logic signed [DW-1:0]    s_q,
   input  logic                    wr_en,
   input  logic [SW-1:0]           wr_sel,
   input  logic [AW-1:0]           wr_addr,
   input  logic signed [CW-1:0]    wr_gi,
   input  logic signed [CW-1:0]    wr_gq,
   output logic signed [DW+CW:0]   p_i,
   output logic signed [DW+CW:0]   p_q
);

   localparam int DEPTH = 1 << AW;
   localparam int MW    = 2 * DW;
   localparam int PW    = DW + CW + 1;
   localparam int SHIFT = MW - AW;

   if (AW > MW) begin : g_bad_aw
      initial $fatal(1, "mpd_branch: AW exceeds the power word width");
   end
   if (TAP_ID >= (1 << SW)) begin : g_bad_id
      initial $fatal(1, "mpd_branch: TAP_ID does not fit the select width");
   end

   // Address from instantaneous power of this branch's own sample.
   logic signed [MW-1:0] sq_i, sq_q;
   logic [MW-1:0]        pwr;
   logic [AW-1:0]        rd_addr;

   always_comb begin
      sq_i    = s_i * s_i;
      sq_q    = s_q * s_q;
      pwr     = $unsigned(sq_i) + $unsigned(sq_q);
      rd_addr = AW'(pwr >> SHIFT);
   end

   // Gain table, one complex word per address.
   logic [2*CW-1:0] mem [DEPTH];
   logic            wr_hit;

   assign wr_hit = wr_en && (wr_sel == SW'(TAP_ID));

   always_ff @(posedge clk) begin
      if (wr_hit) mem[wr_addr] <= {wr_gi, wr_gq};
   end

   // Stage A: registered lookup with aligned sample.
   logic signed [CW-1:0] g_i_r, g_q_r;
   logic signed [DW-1:0] s_i_r, s_q_r;
   logic [2*CW-1:0]      rd_word;

   assign rd_word = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g_i_r <= '0;
         g_q_r <= '0;
         s_i_r <= '0;
         s_q_r <= '0;
      end else begin
         g_i_r <= rd_word[2*CW-1:CW];
         g_q_r <= rd_word[CW-1:0];
         s_i_r <= s_i;
         s_q_r <= s_q;
      end
   end

   // Stage B: complex multiply.
   logic signed [DW+CW-1:0] m_ii, m_qq, m_iq, m_qi;

   always_comb begin
      m_ii = s_i_r * g_i_r;
      m_qq = s_q_r * g_q_r;
      m_iq = s_i_r * g_q_r;
      m_qi = s_q_r * g_i_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_i <= '0;
         p_q <= '0;
      end else begin
         p_i <= PW'(m_ii) - PW'(m_qq);
         p_q <= PW'(m_iq) + PW'(m_qi);
      end
   end

   AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(s_i_r) == '0 && $past(s_q_r) == '0) |-> (p_i == '0 && p_q == '0)); // R3

endmodule

// File: rtl/mpd_round_sat.sv
module mpd_round_sat #(
   parameter int              ACCW     = 36,
   parameter int              DW       = 16,
   parameter int              CFRAC    = 14,
   parameter mpd_pkg::rnd_e   RND_MODE = mpd_pkg::RND_HALF_UP
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   v_in,
   input  logic signed [ACCW-1:0] sum_i,
   input  logic signed [ACCW-1:0] sum_q,
   output logic                   out_valid,
   output logic signed [DW-1:0]   out_i,
   output logic signed [DW-1:0]   out_q
);

   localparam int EW = ACCW + 1;

   if (ACCW < CFRAC + DW + 1) begin : g_bad_accw
      initial $fatal(1, "mpd_round_sat: accumulator too narrow");
   end
   if (CFRAC < 1) begin : g_bad_frac
      initial $fatal(1, "mpd_round_sat: CFRAC must be at least 1");
   end

   localparam logic signed [EW-1:0]   HALF_V = EW'(1) << (CFRAC - 1);
   localparam logic signed [ACCW-1:0] ONE_V  = ACCW'(1) << CFRAC;

   logic signed [EW-1:0] bias;

   if (RND_MODE == mpd_pkg::RND_HALF_UP) begin : g_half_up
      assign bias = HALF_V;
   end else begin : g_trunc
      assign bias = '0;
   end

   function automatic logic signed [DW-1:0] scale_clip(input logic signed [ACCW-1:0] s,
                                                       input logic signed [EW-1:0]   b);
      logic signed [EW-1:0] ext, sh;
      logic                 fits;
      ext  = EW'(s) + b;
      sh   = ext >>> CFRAC;
      fits = (sh[EW-1:DW-1] == '0) || (sh[EW-1:DW-1] == '1);
      if (fits) return sh[DW-1:0];
      return {sh[EW-1], {(DW-1){~sh[EW-1]}}};
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= v_in;
         if (v_in) begin
            out_i <= scale_clip(sum_i, bias);
            out_q <= scale_clip(sum_q, bias);
         end
      end
   end

   AST_SAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sum_i) >= ONE_V) |-> !out_i[DW-1]); // R7
   AST_SAT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sum_q) <= -ONE_V) |-> out_q[DW-1]); // R7

endmodule

// File: rtl/mpd_predistorter.sv
module mpd_predistorter #(
   parameter int            DW       = 16,
   parameter int            CW       = 16,
   parameter int            CFRAC    = 14,
   parameter int            AW       = 8,
   parameter int            TAPS     = 5,
   parameter mpd_pkg::rnd_e RND_MODE = mpd_pkg::RND_HALF_UP,
   localparam int           SW       = (TAPS > 1) ? $clog2(TAPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_i,
   output logic signed [DW-1:0] out_q,
   input  logic                 tbl_we,
   input  logic [SW-1:0]        tbl_sel,
   input  logic [AW-1:0]        tbl_addr,
   input  logic signed [CW-1:0] tbl_gain_i,
   input  logic signed [CW-1:0] tbl_gain_q
);

   localparam int PW   = DW + CW + 1;
   localparam int ACCW = PW + $clog2(TAPS) + 1;

   if (DW < 4 || DW > 30) begin : g_bad_dw
      initial $fatal(1, "mpd_predistorter: DW out of range");
   end
   if (CFRAC >= CW) begin : g_bad_cfrac
      initial $fatal(1, "mpd_predistorter: CFRAC must be below CW");
   end
   if (TAPS < 1 || TAPS > 16) begin : g_bad_taps
      initial $fatal(1, "mpd_predistorter: TAPS out of range");
   end

   // Sample history.
   logic signed [DW-1:0] hist_i [TAPS];
   logic signed [DW-1:0] hist_q [TAPS];

   mpd_delay_line #(.DW(DW), .TAPS(TAPS)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (in_valid),
      .din_i  (in_i),
      .din_q  (in_q),
      .hist_i (hist_i),
      .hist_q (hist_q)
   );

   // Per-branch lookup and multiply.
   logic signed [PW-1:0] prod_i [TAPS];
   logic signed [PW-1:0] prod_q [TAPS];

   for (genvar q = 0; q < TAPS; q++) begin : g_branch
      mpd_branch #(
         .DW(DW), .CW(CW), .AW(AW), .SW(SW), .TAP_ID(q)
      ) u_branch (
         .clk     (clk),
         .rst_n   (rst_n),
         .s_i     (hist_i[q]),
         .s_q     (hist_q[q]),
         .wr_en   (tbl_we),
         .wr_sel  (tbl_sel),
         .wr_addr (tbl_addr),
         .wr_gi   (tbl_gain_i),
         .wr_gq   (tbl_gain_q),
         .p_i     (prod_i[q]),
         .p_q     (prod_q[q])
      );
   end

   // Valid pipeline matching history, lookup and multiply stages.
   logic v_hist, v_look, v_mult;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_hist <= 1'b0;
         v_look <= 1'b0;
         v_mult <= 1'b0;
      end else begin
         v_hist <= in_valid;
         v_look <= v_hist;
         v_mult <= v_look;
      end
   end

   // Sum of branch products.
   logic signed [ACCW-1:0] acc_i, acc_q;

   always_comb begin
      acc_i = '0;
      acc_q = '0;
      for (int q = 0; q < TAPS; q++) begin
         acc_i = acc_i + ACCW'(prod_i[q]);
         acc_q = acc_q + ACCW'(prod_q[q]);
      end
   end

   mpd_round_sat #(
      .ACCW(ACCW), .DW(DW), .CFRAC(CFRAC), .RND_MODE(RND_MODE)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .v_in      (v_mult),
      .sum_i     (acc_i),
      .sum_q     (acc_q),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   AST_LAT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##4 out_valid); // R2
   AST_LAT_BWD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 4)); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q))); // R10

endmodule

// File: tb/mpd_predistorter_tb.sv
module mpd_predistorter_tb;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic signed [15:0] in_i = '0, in_q = '0;
   logic              out_valid;
   logic signed [15:0] out_i, out_q;
   logic              tbl_we = 1'b0;
   logic [2:0]        tbl_sel = '0;
   logic [7:0]        tbl_addr = '0;
   logic signed [15:0] tbl_gain_i = '0, tbl_gain_q = '0;

   always #4 clk = ~clk;   // 125 MHz

   mpd_predistorter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
      .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
      .tbl_gain_i(tbl_gain_i), .tbl_gain_q(tbl_gain_q)
   );

   int checks = 0;
   int failures = 0;
   longint cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference tables and history.
   int gt_i [5][256];
   int gt_q [5][256];
   longint mh_i [5];
   longint mh_q [5];

   // Scoreboard queues.
   int     eq_i [$];
   int     eq_q [$];
   longint eq_c [$];
   string  eq_t [$];

   function automatic int gain_re(int q, int a);
      if (q == 0) begin
         if (a == 0)   return 8192;
         if (a >= 100) return 30000;
         return 16384 - a * 40;
      end
      if (a == 0) return 0;
      return ((a * 13 + q * 101) % 2048) - 1024;
   endfunction

   function automatic int gain_im(int q, int a);
      if (q == 0) begin
         if (a == 0)   return 0;
         if (a >= 100) return 500;
         return a * 10 - 300;
      end
      if (a == 0) return 0;
      return ((a * 29 + q * 53) % 1024) - 512;
   endfunction

   function automatic int clip16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(int si, int sq, string tag);
      longint acc_i, acc_q;
      @(negedge clk);
      in_valid = 1'b1;
      in_i = 16'(si);
      in_q = 16'(sq);
      for (int q = 4; q > 0; q--) begin
         mh_i[q] = mh_i[q-1];
         mh_q[q] = mh_q[q-1];
      end
      mh_i[0] = si;
      mh_q[0] = sq;
      acc_i = 0;
      acc_q = 0;
      for (int q = 0; q < 5; q++) begin
         longint p;
         int a;
         p = mh_i[q] * mh_i[q] + mh_q[q] * mh_q[q];
         a = int'((p >> 24) & 255);   // R4 own-branch address
         acc_i += mh_i[q] * gt_i[q][a] - mh_q[q] * gt_q[q][a];
         acc_q += mh_i[q] * gt_q[q][a] + mh_q[q] * gt_i[q][a];
      end
      eq_i.push_back(clip16((acc_i + 8192) >>> 14));
      eq_q.push_back(clip16((acc_q + 8192) >>> 14));
      eq_c.push_back(cyc + 4);
      eq_t.push_back(tag);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic tbl_write(int sel, int a, int gi, int gq);
      @(negedge clk);
      tbl_we = 1'b1;
      tbl_sel = 3'(sel);
      tbl_addr = 8'(a);
      tbl_gain_i = 16'(gi);
      tbl_gain_q = 16'(gq);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      check(out_i == 0 && out_q == 0, "R1 output data in reset", out_i, 0);
      for (int q = 0; q < 5; q++) begin
         mh_i[q] = 0;
         mh_q[q] = 0;
      end
      rst_n = 1'b1;
   endtask

   // Monitor: pops expectations as results appear.
   logic signed [15:0] prev_i = '0, prev_q = '0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (eq_i.size() == 0) begin
               check(1'b0, "R2 unexpected out_valid", 1, 0);
            end else begin
               int ei, eqv;
               longint ec;
               string et;
               ei = eq_i.pop_front();
               eqv = eq_q.pop_front();
               ec = eq_c.pop_front();
               et = eq_t.pop_front();
               check(ec == cyc, "R2 output latency", cyc, ec);
               check(out_i == ei, {et, " R3 real part"}, out_i, ei);
               check(out_q == eqv, {et, " R3 imaginary part"}, out_q, eqv);
            end
         end else begin
            if (eq_c.size() > 0 && eq_c[0] <= cyc)
               check(1'b0, "R2 missing out_valid", cyc, eq_c[0]);
            check(out_i == prev_i && out_q == prev_q, "R10 hold while idle", out_i, prev_i);
         end
      end
      prev_i = out_i;
      prev_q = out_q;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int q = 0; q < 5; q++) begin
         mh_i[q] = 0;
         mh_q[q] = 0;
      end
      repeat (2) @(negedge clk);
      do_reset();

      // R8: load every table.
      for (int q = 0; q < 5; q++) begin
         for (int a = 0; a < 256; a++) begin
            gt_i[q][a] = gain_re(q, a);
            gt_q[q][a] = gain_im(q, a);
            tbl_write(q, a, gt_i[q][a], gt_q[q][a]);
         end
      end
      // R9: writes to absent branches; address 10 is used below.
      for (int s = 5; s < 8; s++) tbl_write(s, 10, 32767, -32768);
      @(negedge clk);
      tbl_we = 1'b0;
      idle(2);
      do_reset();

      // R6 R1: half gain on zero history; 0.5 -> 1, -0.5 -> 0, 1.5 -> 2.
      push(1, 0, "R6 R1 tie up");
      push(-1, 0, "R6 tie negative");
      push(3, 0, "R6 tie 1.5");
      push(0, 1, "R6 imaginary tie");
      idle(8);

      // R9: samples at address 10 (13000^2 >> 24 = 10).
      push(13000, 0, "R9 bad-select write ignored");
      push(0, 13000, "R9 bad-select write ignored");
      push(-13000, 0, "R9 bad-select write ignored");
      idle(6);

      // R7: full-scale drive saturates.
      push(32767, 32767, "R7 positive clamp");
      push(-32768, -32768, "R7 negative clamp");
      push(32767, -32768, "R7 mixed clamp");
      idle(6);

      // R4: alternating amplitudes make branch addresses differ from current.
      for (int k = 0; k < 40; k++) begin
         if (k % 2 == 0) push(30000, -20000, "R4 own-branch address");
         else            push(200, 150, "R4 own-branch address");
      end
      idle(6);

      // R5: gaps between samples must not shift history.
      for (int k = 0; k < 30; k++) begin
         push(1000 * k - 15000, 20000 - 900 * k, "R5 gaps keep history");
         idle(1 + (k % 3));
      end
      idle(6);

      // R3: random stream with random idle cycles.
      for (int k = 0; k < 3000; k++) begin
         if ($urandom_range(0, 9) < 7) begin
            int sc, vi, vq;
            sc = $urandom_range(0, 3);
            vi = int'($urandom_range(0, 65535)) - 32768;
            vq = int'($urandom_range(0, 65535)) - 32768;
            push(vi >>> (sc * 4), vq >>> (sc * 4), "R3 random stream");
         end else begin
            idle(1);
         end
      end
      idle(8);

      // R1: reset mid-run clears history.
      do_reset();
      push(20000, 10000, "R1 history cleared");
      push(5, 5, "R1 history cleared");
      idle(8);

      check(eq_i.size() == 0, "R2 all outputs delivered", eq_i.size(), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule